// File: doc/BRIEF.md
# Retirement Trace Record Serializer

This block takes the values a core reports when it retires an instruction and stores them as one fixed-format execution record. It then sends the record out one byte at a time over a valid/ready byte channel. The inputs are the retired-instruction count, the program counter before and after the instruction, the instruction word, the source and destination register indices and values, the memory access (address, read and write data, read and write widths in bytes), and the trap, halt and interrupt flags. A trace consumer at the far end can then compare the record field by field against a reference model.

Before the record is stored, the block applies the consistency rules a checker expects. It zeroes a register value whose index is zero and zeroes the destination index when nothing is written. It zeroes memory fields that take part in no access, and it turns the access widths into byte masks. It can also emit a halt-only record on request. The record is `10*WORD_BYTES+8` bytes long, which is 88 bytes with the defaults. A new record is accepted only while the serializer is idle.

Top module: `retire_trace_serializer`

## Requirements
- R1: With the defaults the record is 88 bytes, sent lowest byte first. Each of ten 8-byte fields is sent least significant byte first, in this order: byte 0 retired count, 8 PC before, 16 PC after, 24 instruction (zero-extended from 32 bits), 32 rs1 value, 40 rs2 value, 48 rd value, 56 memory address, 64 memory read data, 72 memory write data. Single bytes follow: 80 read mask, 81 write mask, 82 rs1 index, 83 rs2 index, 84 rd index, 85 trap, 86 halt, 87 interrupt.
- R2: The rd index byte is zero when `ret_rd_we` is 0. The rd value field is zero whenever the rd index that is sent is zero.
- R3: The rs1 value field is zero when `ret_rs1_idx` is zero, and the rs2 value field is zero when `ret_rs2_idx` is zero.
- R4: A mask is 0x00 for width 0, (2^w)-1 for a width w from 1 to 8, and 0xFF for any width above 8. The read mask comes from `ret_mem_rwidth` and the write mask from `ret_mem_wwidth`.
- R5: The read data field is zero when the read width is 0, and the write data field is zero when the write width is 0. The memory address field is zero when both widths are 0.
- R6: The trap, halt and interrupt bytes are 0x01 when the matching input flag is set and 0x00 otherwise.
- R7: A `halt_req` seen while idle captures a halt-only record: every byte 0x00 except byte 86, which is 0x01. `halt_req` wins over `retire_valid` in the same cycle, and `retire_ready` is low while `halt_req` is high.
- R8: A record is captured only when idle. `retire_ready` stays low from the capture until the last byte is accepted, and a `retire_valid` raised in that time starts no further record.
- R9: The serializer moves to the next byte only when `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R10: `rec_done` is high exactly in the cycle in which byte 87 is accepted. `tx_valid` is low in the next cycle.
- R11: A synchronous reset returns the block to idle with `tx_valid` low, `retire_ready` high and the stored record cleared. The next capture starts again from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire_valid | input | 1 | Retirement values are present |
| retire_ready | output | 1 | Serializer idle and no halt request pending |
| halt_req | input | 1 | Request a halt-only record |
| ret_order | input | 64 | Retired-instruction count after this instruction |
| ret_pc_before | input | 64 | PC of the instruction |
| ret_pc_after | input | 64 | Next PC |
| ret_insn | input | 32 | Instruction word |
| ret_rs1_idx | input | 5 | First source register index |
| ret_rs1_val | input | 64 | First source register value |
| ret_rs2_idx | input | 5 | Second source register index |
| ret_rs2_val | input | 64 | Second source register value |
| ret_rd_we | input | 1 | A destination register is written |
| ret_rd_idx | input | 5 | Destination register index |
| ret_rd_val | input | 64 | Destination register value |
| ret_mem_addr | input | 64 | Memory byte address |
| ret_mem_rwidth | input | 4 | Read width in bytes, 0 for no read |
| ret_mem_wwidth | input | 4 | Write width in bytes, 0 for no write |
| ret_mem_rdata | input | 64 | Data read |
| ret_mem_wdata | input | 64 | Data written |
| ret_trap | input | 1 | Trap flag |
| ret_halt | input | 1 | Halt flag |
| ret_intr | input | 1 | First instruction of a trap handler |
| tx_data | output | 8 | Outgoing record byte |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Consumer takes the byte |
| rec_done | output | 1 | Last byte of the record accepted |

## Verification
The bench uses the default parameters: 8-byte fields, 5-bit register indices and 4-bit access widths, which give the full 88-byte record. With 4-bit widths the bench can sweep every read width against every write width from 0 to 9. That covers each mask value, the clamp above 8 and the no-access zeroing in a hundred records. Register indices, write enables and flags vary along the sweep, and a pseudo-random `tx_ready` pattern applies back-pressure at varying byte positions.

// File: rtl/rtrace_pkg.sv
package rtrace_pkg;

  // Ten wide fields precede the single-byte tail of the record.
  localparam int unsigned WORD_FIELDS = 10;
  localparam int unsigned TAIL_BYTES  = 8;
  // Position of the halt byte inside the tail (consumer decodes it here).
  localparam int unsigned HALT_SLOT   = 6;
  localparam int unsigned ACC_W       = 4;

  typedef enum logic {ST_IDLE, ST_SEND} ser_state_e;

  // Byte mask for an access width; widths beyond max_bytes saturate.
  function automatic logic [7:0] width_to_mask(input logic [ACC_W-1:0] width,
                                               input int unsigned max_bytes);
    int unsigned w;
    w = 32'(width);
    if (w > max_bytes) w = max_bytes;
    if (w == 0) return 8'h00;
    return 8'hFF >> (8 - w);
  endfunction

  function automatic logic [7:0] flag_byte(input logic f);
    return {7'b0, f};
  endfunction

endpackage

// File: rtl/rtrace_field_rules.sv
module rtrace_field_rules
  import rtrace_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned REG_IDX_W  = 5,
  localparam int unsigned FIELD_W   = 8 * WORD_BYTES
) (
  input  logic                 rd_we,
  input  logic [REG_IDX_W-1:0] rd_idx,
  input  logic [FIELD_W-1:0]   rd_val,
  input  logic [REG_IDX_W-1:0] rs1_idx,
  input  logic [FIELD_W-1:0]   rs1_val,
  input  logic [REG_IDX_W-1:0] rs2_idx,
  input  logic [FIELD_W-1:0]   rs2_val,
  input  logic [FIELD_W-1:0]   mem_addr,
  input  logic [ACC_W-1:0]     rwidth,
  input  logic [ACC_W-1:0]     wwidth,
  input  logic [FIELD_W-1:0]   rdata,
  input  logic [FIELD_W-1:0]   wdata,
  output logic [7:0]           rd_idx_o,
  output logic [FIELD_W-1:0]   rd_val_o,
  output logic [7:0]           rs1_idx_o,
  output logic [FIELD_W-1:0]   rs1_val_o,
  output logic [7:0]           rs2_idx_o,
  output logic [FIELD_W-1:0]   rs2_val_o,
  output logic [FIELD_W-1:0]   mem_addr_o,
  output logic [FIELD_W-1:0]   rdata_o,
  output logic [FIELD_W-1:0]   wdata_o,
  output logic [7:0]           rmask_o,
  output logic [7:0]           wmask_o
);

  localparam int unsigned IDX_PAD = 8 - REG_IDX_W;

  logic [REG_IDX_W-1:0] rd_idx_eff;
  logic                 rd_live;
  logic                 rd_access;
  logic                 wr_access;

  always_comb begin
    rd_idx_eff = rd_we ? rd_idx : '0;
    rd_live    = (rd_idx_eff != '0);
    rd_access  = (rwidth != '0);
    wr_access  = (wwidth != '0);

    rd_idx_o   = {{IDX_PAD{1'b0}}, rd_idx_eff};
    rd_val_o   = rd_live ? rd_val : '0;

    rs1_idx_o  = {{IDX_PAD{1'b0}}, rs1_idx};
    rs1_val_o  = (rs1_idx != '0) ? rs1_val : '0;
    rs2_idx_o  = {{IDX_PAD{1'b0}}, rs2_idx};
    rs2_val_o  = (rs2_idx != '0) ? rs2_val : '0;

    mem_addr_o = (rd_access || wr_access) ? mem_addr : '0;
    rdata_o    = rd_access ? rdata : '0;
    wdata_o    = wr_access ? wdata : '0;
    rmask_o    = width_to_mask(rwidth, WORD_BYTES);
    wmask_o    = width_to_mask(wwidth, WORD_BYTES);
  end

endmodule

// File: rtl/rtrace_record_pack.sv
module rtrace_record_pack
  import rtrace_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned INSN_W     = 32,
  localparam int unsigned FIELD_W   = 8 * WORD_BYTES,
  localparam int unsigned REC_BYTES = WORD_FIELDS * WORD_BYTES + TAIL_BYTES,
  localparam int unsigned REC_W     = 8 * REC_BYTES
) (
  input  logic               halt_only,
  input  logic [FIELD_W-1:0] order,
  input  logic [FIELD_W-1:0] pc_before,
  input  logic [FIELD_W-1:0] pc_after,
  input  logic [INSN_W-1:0]  insn,
  input  logic [FIELD_W-1:0] rs1_val,
  input  logic [FIELD_W-1:0] rs2_val,
  input  logic [FIELD_W-1:0] rd_val,
  input  logic [FIELD_W-1:0] mem_addr,
  input  logic [FIELD_W-1:0] rdata,
  input  logic [FIELD_W-1:0] wdata,
  input  logic [7:0]         rmask,
  input  logic [7:0]         wmask,
  input  logic [7:0]         rs1_idx,
  input  logic [7:0]         rs2_idx,
  input  logic [7:0]         rd_idx,
  input  logic               trap,
  input  logic               halt,
  input  logic               intr,
  output logic [REC_W-1:0]   rec
);

  localparam int unsigned TAIL_BASE = 8 * WORD_FIELDS * WORD_BYTES;
  localparam int unsigned HALT_BIT  = TAIL_BASE + 8 * HALT_SLOT;

  logic [FIELD_W-1:0] word_a [WORD_FIELDS];
  logic [7:0]         tail_a [TAIL_BYTES];
  logic [REC_W-1:0]   body;
  logic [REC_W-1:0]   halt_rec;

  // Field order is fixed: the consumer decodes by byte position.
  assign word_a[0] = order;
  assign word_a[1] = pc_before;
  assign word_a[2] = pc_after;
  assign word_a[3] = {{(FIELD_W-INSN_W){1'b0}}, insn};
  assign word_a[4] = rs1_val;
  assign word_a[5] = rs2_val;
  assign word_a[6] = rd_val;
  assign word_a[7] = mem_addr;
  assign word_a[8] = rdata;
  assign word_a[9] = wdata;

  assign tail_a[0] = rmask;
  assign tail_a[1] = wmask;
  assign tail_a[2] = rs1_idx;
  assign tail_a[3] = rs2_idx;
  assign tail_a[4] = rd_idx;
  assign tail_a[5] = flag_byte(trap);
  assign tail_a[6] = flag_byte(halt);
  assign tail_a[7] = flag_byte(intr);

  for (genvar gw = 0; gw < WORD_FIELDS; gw++) begin : g_word
    assign body[gw*FIELD_W +: FIELD_W] = word_a[gw];
  end
  for (genvar gt = 0; gt < TAIL_BYTES; gt++) begin : g_tail
    assign body[TAIL_BASE + gt*8 +: 8] = tail_a[gt];
  end

  always_comb begin
    halt_rec           = '0;
    halt_rec[HALT_BIT] = 1'b1;
  end

  assign rec = halt_only ? halt_rec : body;

endmodule

// File: rtl/rtrace_byte_stream.sv
module rtrace_byte_stream
  import rtrace_pkg::*;
#(
  parameter int unsigned REC_BYTES = 88,
  localparam int unsigned REC_W    = 8 * REC_BYTES,
  localparam int unsigned CNT_W    = $clog2(REC_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REC_W-1:0] load_rec,
  input  logic             last_byte,
  input  logic             tx_ready,
  output logic             idle,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             byte_fire,
  output logic [CNT_W-1:0] byte_cnt
);

  ser_state_e       state_q;
  logic [REC_W-1:0] shreg_q;
  logic [CNT_W-1:0] cnt_q;

  assign idle      = (state_q == ST_IDLE);
  assign tx_valid  = (state_q == ST_SEND);
  assign tx_data   = shreg_q[7:0];
  assign byte_fire = tx_valid && tx_ready;
  assign byte_cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (load) begin
            shreg_q <= load_rec;
            cnt_q   <= '0;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (byte_fire) begin
            shreg_q <= shreg_q >> 8;
            if (last_byte) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/retire_trace_serializer.sv
module retire_trace_serializer
  import rtrace_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned REG_IDX_W  = 5,
  parameter int unsigned INSN_W     = 32,
  localparam int unsigned FIELD_W   = 8 * WORD_BYTES,
  localparam int unsigned REC_BYTES = WORD_FIELDS * WORD_BYTES + TAIL_BYTES,
  localparam int unsigned REC_W     = 8 * REC_BYTES,
  localparam int unsigned CNT_W     = $clog2(REC_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 retire_valid,
  output logic                 retire_ready,
  input  logic                 halt_req,
  input  logic [FIELD_W-1:0]   ret_order,
  input  logic [FIELD_W-1:0]   ret_pc_before,
  input  logic [FIELD_W-1:0]   ret_pc_after,
  input  logic [INSN_W-1:0]    ret_insn,
  input  logic [REG_IDX_W-1:0] ret_rs1_idx,
  input  logic [FIELD_W-1:0]   ret_rs1_val,
  input  logic [REG_IDX_W-1:0] ret_rs2_idx,
  input  logic [FIELD_W-1:0]   ret_rs2_val,
  input  logic                 ret_rd_we,
  input  logic [REG_IDX_W-1:0] ret_rd_idx,
  input  logic [FIELD_W-1:0]   ret_rd_val,
  input  logic [FIELD_W-1:0]   ret_mem_addr,
  input  logic [ACC_W-1:0]     ret_mem_rwidth,
  input  logic [ACC_W-1:0]     ret_mem_wwidth,
  input  logic [FIELD_W-1:0]   ret_mem_rdata,
  input  logic [FIELD_W-1:0]   ret_mem_wdata,
  input  logic                 ret_trap,
  input  logic                 ret_halt,
  input  logic                 ret_intr,
  output logic [7:0]           tx_data,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic                 rec_done
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(REC_BYTES - 1);

  // Named internal events, visible to the bound checker.
  logic             idle;
  logic             capture_fire;
  logic             byte_fire;
  logic             last_byte;
  logic [CNT_W-1:0] byte_cnt;
  logic [REC_W-1:0] next_rec;

  logic [7:0]         c_rd_idx, c_rs1_idx, c_rs2_idx, c_rmask, c_wmask;
  logic [FIELD_W-1:0] c_rd_val, c_rs1_val, c_rs2_val;
  logic [FIELD_W-1:0] c_addr, c_rdata, c_wdata;

  assign retire_ready = idle && !halt_req;
  assign capture_fire = idle && (halt_req || retire_valid);
  assign last_byte    = (byte_cnt == LAST_IDX);
  assign rec_done     = byte_fire && last_byte;

  rtrace_field_rules #(
    .WORD_BYTES(WORD_BYTES),
    .REG_IDX_W (REG_IDX_W)
  ) u_rules (
    .rd_we     (ret_rd_we),
    .rd_idx    (ret_rd_idx),
    .rd_val    (ret_rd_val),
    .rs1_idx   (ret_rs1_idx),
    .rs1_val   (ret_rs1_val),
    .rs2_idx   (ret_rs2_idx),
    .rs2_val   (ret_rs2_val),
    .mem_addr  (ret_mem_addr),
    .rwidth    (ret_mem_rwidth),
    .wwidth    (ret_mem_wwidth),
    .rdata     (ret_mem_rdata),
    .wdata     (ret_mem_wdata),
    .rd_idx_o  (c_rd_idx),
    .rd_val_o  (c_rd_val),
    .rs1_idx_o (c_rs1_idx),
    .rs1_val_o (c_rs1_val),
    .rs2_idx_o (c_rs2_idx),
    .rs2_val_o (c_rs2_val),
    .mem_addr_o(c_addr),
    .rdata_o   (c_rdata),
    .wdata_o   (c_wdata),
    .rmask_o   (c_rmask),
    .wmask_o   (c_wmask)
  );

  rtrace_record_pack #(
    .WORD_BYTES(WORD_BYTES),
    .INSN_W    (INSN_W)
  ) u_pack (
    .halt_only(halt_req),
    .order    (ret_order),
    .pc_before(ret_pc_before),
    .pc_after (ret_pc_after),
    .insn     (ret_insn),
    .rs1_val  (c_rs1_val),
    .rs2_val  (c_rs2_val),
    .rd_val   (c_rd_val),
    .mem_addr (c_addr),
    .rdata    (c_rdata),
    .wdata    (c_wdata),
    .rmask    (c_rmask),
    .wmask    (c_wmask),
    .rs1_idx  (c_rs1_idx),
    .rs2_idx  (c_rs2_idx),
    .rd_idx   (c_rd_idx),
    .trap     (ret_trap),
    .halt     (ret_halt),
    .intr     (ret_intr),
    .rec      (next_rec)
  );

  rtrace_byte_stream #(
    .REC_BYTES(REC_BYTES)
  ) u_stream (
    .clk      (clk),
    .rst      (rst),
    .load     (capture_fire),
    .load_rec (next_rec),
    .last_byte(last_byte),
    .tx_ready (tx_ready),
    .idle     (idle),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .byte_fire(byte_fire),
    .byte_cnt (byte_cnt)
  );

endmodule

// File: rtl/rtrace_checker.sv
module rtrace_checker #(
  parameter int unsigned REC_BYTES = 88,
  localparam int unsigned CNT_W    = $clog2(REC_BYTES)
) (
  input logic             clk,
  input logic             rst,
  input logic             retire_ready,
  input logic             halt_req,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             rec_done,
  input logic             capture_fire,
  input logic [CNT_W-1:0] byte_cnt
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(REC_BYTES - 1);

  assert_busy_blocks_retire_R8: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !retire_ready);

  assert_capture_starts_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
    capture_fire |=> (tx_valid && byte_cnt == '0));

  assert_stall_holds_byte_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_count_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= LAST_IDX);

  assert_done_then_idle_R10: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> !tx_valid);

  assert_halt_record_opens_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (capture_fire && halt_req) |=> (tx_data == 8'h00));

  assert_reset_clears_valid_R11: assert property (@(posedge clk)
    rst |=> !tx_valid);

endmodule

bind retire_trace_serializer rtrace_checker #(.REC_BYTES(REC_BYTES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .retire_ready(retire_ready),
  .halt_req    (halt_req),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .rec_done    (rec_done),
  .capture_fire(capture_fire),
  .byte_cnt    (byte_cnt)
);

// File: tb/retire_trace_serializer_test.sv
module retire_trace_serializer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 88;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire_valid = 1'b0;
  logic        retire_ready;
  logic        halt_req = 1'b0;
  logic [63:0] ret_order = '0, ret_pc_before = '0, ret_pc_after = '0;
  logic [31:0] ret_insn = '0;
  logic [4:0]  ret_rs1_idx = '0, ret_rs2_idx = '0, ret_rd_idx = '0;
  logic [63:0] ret_rs1_val = '0, ret_rs2_val = '0, ret_rd_val = '0;
  logic        ret_rd_we = 1'b0;
  logic [63:0] ret_mem_addr = '0, ret_mem_rdata = '0, ret_mem_wdata = '0;
  logic [3:0]  ret_mem_rwidth = '0, ret_mem_wwidth = '0;
  logic        ret_trap = 1'b0, ret_halt = 1'b0, ret_intr = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        rec_done;

  int checks = 0;
  int failures = 0;
  logic [7:0]  exp_b [NBYTES];
  logic [7:0]  got_b [NBYTES];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  retire_trace_serializer uut (
    .clk(clk), .rst(rst), .retire_valid(retire_valid), .retire_ready(retire_ready),
    .halt_req(halt_req), .ret_order(ret_order), .ret_pc_before(ret_pc_before),
    .ret_pc_after(ret_pc_after), .ret_insn(ret_insn), .ret_rs1_idx(ret_rs1_idx),
    .ret_rs1_val(ret_rs1_val), .ret_rs2_idx(ret_rs2_idx), .ret_rs2_val(ret_rs2_val),
    .ret_rd_we(ret_rd_we), .ret_rd_idx(ret_rd_idx), .ret_rd_val(ret_rd_val),
    .ret_mem_addr(ret_mem_addr), .ret_mem_rwidth(ret_mem_rwidth),
    .ret_mem_wwidth(ret_mem_wwidth), .ret_mem_rdata(ret_mem_rdata),
    .ret_mem_wdata(ret_mem_wdata), .ret_trap(ret_trap), .ret_halt(ret_halt),
    .ret_intr(ret_intr), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rec_done(rec_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int mask_of(input int w);
    if (w == 0) return 0;
    if (w >= 8) return 255;
    return (1 << w) - 1;
  endfunction

  task automatic put_word(input int base, input logic [63:0] v);
    for (int i = 0; i < 8; i++) exp_b[base + i] = v[8*i +: 8];
  endtask

  task automatic build_exp(input bit halt_only);
    logic [4:0] rd_i;
    bit any_mem;
    for (int k = 0; k < NBYTES; k++) exp_b[k] = 8'h00;
    if (halt_only) begin
      exp_b[86] = 8'h01;
      return;
    end
    rd_i    = ret_rd_we ? ret_rd_idx : 5'd0;
    any_mem = (ret_mem_rwidth != 0) || (ret_mem_wwidth != 0);
    put_word(0,  ret_order);
    put_word(8,  ret_pc_before);
    put_word(16, ret_pc_after);
    put_word(24, {32'h0, ret_insn});
    put_word(32, (ret_rs1_idx != 0) ? ret_rs1_val : 64'h0);
    put_word(40, (ret_rs2_idx != 0) ? ret_rs2_val : 64'h0);
    put_word(48, (rd_i != 0) ? ret_rd_val : 64'h0);
    put_word(56, any_mem ? ret_mem_addr : 64'h0);
    put_word(64, (ret_mem_rwidth != 0) ? ret_mem_rdata : 64'h0);
    put_word(72, (ret_mem_wwidth != 0) ? ret_mem_wdata : 64'h0);
    exp_b[80] = 8'(mask_of(int'(ret_mem_rwidth)));
    exp_b[81] = 8'(mask_of(int'(ret_mem_wwidth)));
    exp_b[82] = {3'b0, ret_rs1_idx};
    exp_b[83] = {3'b0, ret_rs2_idx};
    exp_b[84] = {3'b0, rd_i};
    exp_b[85] = ret_trap ? 8'h01 : 8'h00;
    exp_b[86] = ret_halt ? 8'h01 : 8'h00;
    exp_b[87] = ret_intr ? 8'h01 : 8'h00;
  endtask

  // mode: 0 = always ready, 1 = pseudo-random back-pressure
  task automatic run_record(input bit use_halt, input int mode,
                            input bit poke_busy, input string tag);
    int n = 0;
    int guard = 0;
    int bad = 0;
    int first = 0;
    bit held = 0;
    logic [7:0] held_data = '0;
    build_exp(use_halt);
    @(negedge clk);
    if (use_halt) begin
      halt_req = 1'b1;
      retire_valid = 1'b1;
      #1 chk(retire_ready == 1'b0, "R7", "ready low under halt_req", retire_ready, 0);
    end else begin
      retire_valid = 1'b1;
    end
    @(negedge clk);
    halt_req = 1'b0;
    retire_valid = 1'b0;
    while (n < NBYTES && guard < 4000) begin
      if (mode == 0) tx_ready = 1'b1;
      else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = lfsr[0] | lfsr[3];
      end
      retire_valid = poke_busy && (n == 40);
      #1;
      if (held) begin
        chk(tx_valid && tx_data == held_data, "R9", "byte held under stall",
            tx_data, held_data);
      end
      if (poke_busy && n == 40)
        chk(retire_ready == 1'b0, "R8", "ready low while sending", retire_ready, 0);
      held = tx_valid && !tx_ready;
      held_data = tx_data;
      if (tx_valid && tx_ready) begin
        got_b[n] = tx_data;
        if ((n == NBYTES - 1) != rec_done) begin
          chk(0, "R10", "done at byte", rec_done, (n == NBYTES - 1));
        end
        n++;
      end else if (rec_done) begin
        chk(0, "R10", "done without handshake", rec_done, 0);
      end
      @(negedge clk);
      guard++;
    end
    retire_valid = 1'b0;
    tx_ready = 1'b0;
    #1 chk(n == NBYTES, tag, "bytes received", n, NBYTES);
    chk(tx_valid == 1'b0, "R10", "idle after last byte", tx_valid, 0);
    for (int k = 0; k < NBYTES; k++) begin
      if (got_b[k] !== exp_b[k]) begin
        if (bad == 0) first = k;
        bad++;
      end
    end
    chk(bad == 0, tag, $sformatf("record byte %0d", first), got_b[first], exp_b[first]);
    if (!use_halt) begin
      chk(got_b[80] == exp_b[80], "R4", "read mask", got_b[80], exp_b[80]);
      chk(got_b[81] == exp_b[81], "R4", "write mask", got_b[81], exp_b[81]);
    end
    if (poke_busy) begin
      @(negedge clk);
      #1 chk(tx_valid == 1'b0, "R8", "no record from busy-time retire", tx_valid, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(tx_valid == 1'b0, "R11", "tx_valid after reset", tx_valid, 0);
    chk(retire_ready == 1'b1, "R11", "retire_ready after reset", retire_ready, 1);
    chk(rec_done == 1'b0, "R10", "rec_done after reset", rec_done, 0);

    // R1: base layout with every field distinct and always-ready consumer
    ret_order = 64'h0807_0605_0403_0201; ret_pc_before = 64'h1817_1615_1413_1211;
    ret_pc_after = 64'h2827_2625_2423_2221; ret_insn = 32'h3433_3231;
    ret_rs1_idx = 5'd3; ret_rs1_val = 64'h4847_4645_4443_4241;
    ret_rs2_idx = 5'd7; ret_rs2_val = 64'h5857_5655_5453_5251;
    ret_rd_we = 1'b1; ret_rd_idx = 5'd31; ret_rd_val = 64'h6867_6665_6463_6261;
    ret_mem_addr = 64'h7877_7675_7473_7271; ret_mem_rwidth = 4'd8; ret_mem_wwidth = 4'd4;
    ret_mem_rdata = 64'h8887_8685_8483_8281; ret_mem_wdata = 64'h9897_9695_9493_9291;
    ret_trap = 1'b1; ret_halt = 1'b0; ret_intr = 1'b1;
    run_record(1'b0, 0, 1'b0, "R1");

    // R2 R3 R4 R5 R6: sweep all width pairs with back-pressure
    for (int r = 0; r < 10; r++) begin
      for (int w = 0; w < 10; w++) begin
        ret_order      = 64'(r * 16 + w) ^ 64'hC0DE_0000_0000_0000;
        ret_mem_rwidth = 4'(r);
        ret_mem_wwidth = 4'(w);
        ret_rd_we      = r[0];
        ret_rd_idx     = (w % 3 == 0) ? 5'd0 : 5'(w + 1);
        ret_rs1_idx    = r[1] ? 5'(r) : 5'd0;
        ret_rs2_idx    = w[0] ? 5'(w + 8) : 5'd0;
        ret_trap       = r[0];
        ret_halt       = w[0];
        ret_intr       = r[1] ^ w[1];
        ret_mem_addr   = {32'hA5A5_0000, 16'(r), 16'(w)};
        run_record(1'b0, 1, 1'b0, "R2 R3 R5 R6");
      end
    end

    // R7: halt-only record wins over a simultaneous retire
    run_record(1'b1, 1, 1'b0, "R7");

    // R8: retire raised during a record is ignored
    run_record(1'b0, 0, 1'b1, "R8");

    // R11: reset in the middle of a record
    @(negedge clk);
    retire_valid = 1'b1;
    @(negedge clk);
    retire_valid = 1'b0;
    tx_ready = 1'b1;
    repeat (10) @(negedge clk);
    tx_ready = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(tx_valid == 1'b0, "R11", "tx_valid after mid-record reset", tx_valid, 0);
    chk(retire_ready == 1'b1, "R11", "ready after mid-record reset", retire_ready, 1);
    run_record(1'b0, 1, 1'b0, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule